// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block looks at every pending interrupt request in a cycle and picks the one the processor should service next. It registers a valid flag, the 16-bit vector word address of the winner and the winner's priority level. It also sends a one-cycle acknowledge to the winning source, which that source uses to drop its request.

Five requests cannot be masked by a level: reset, NMI, watchdog, zero divide and address match. They win in a fixed order over everything else. Behind them sits a group of maskable peripheral and external sources, eighteen by default. Each carries a 3-bit software level. A maskable source is eligible only when global enable is set and its level is strictly above the processor's current priority level. Among eligible maskable sources the highest level wins, and on a tie the source with the higher vector address wins. The two vector slots reserved for the breakpoint and debug traps are never produced. Stack handling and the processor's sequencing are left to the core.

Top module: `irq_vec_resolver`

## Requirements
- R1: A reset request wins over every other request and yields vector 0xFFFE with `rst_ack_o`.
- R2: An NMI request loses only to reset and yields vector 0xFFF4 with `nmi_ack_o`.
- R3: A watchdog request loses only to reset and NMI and yields vector 0xFFF6 with `wdt_ack_o`.
- R4: Zero divide (0xFFFC) and then address match (0xFFCA) rank next. Both beat every maskable source whatever `ie_i` and `ipl_i` are.
- R5: Maskable source k (bit k of `irq_req_i`, level in `irq_lvl_i[3k+2:3k]`) has vector 0xFFF2 - 2k. Sources k=0..17 are INT0, INT1, INT2, timer A0..A4, timer B0..B2, UART0 rx, UART0 tx, UART1 rx, UART1 tx, A-D, INT3 and INT4, which puts INT4 at 0xFFD0.
- R6: A maskable source is serviced only if `ie_i` is 1 and its level is strictly greater than `ipl_i`. A source at level 0 is never serviced.
- R7: Among eligible maskable sources the highest level wins. On equal levels the lowest k (the higher vector) wins.
- R8: `lvl_o` holds the winner's level for a maskable winner and 7 for a fixed-order winner.
- R9: Outputs are registered: they reflect the inputs sampled at the previous rising edge. With no serviceable request, `valid_o`, `vec_o`, `lvl_o` and all acknowledges are 0.
- R10: At most one acknowledge is high in a cycle. It belongs to the source whose vector is on `vec_o`, and one is high exactly when `valid_o` is 1.
- R11: Vectors 0xFFFA and 0xFFF8 are never output.
- R12: While `rst_ni` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset request |
| nmi_req_i | input | 1 | NMI request |
| wdt_req_i | input | 1 | Watchdog request |
| zdiv_req_i | input | 1 | Zero divide request |
| amatch_req_i | input | 1 | Address match request |
| irq_req_i | input | N_MASK | Maskable requests, bit k is source k |
| irq_lvl_i | input | N_MASK*LVL_W | Level of source k in bits [LVL_W*k +: LVL_W] |
| ipl_i | input | LVL_W | Processor's current priority level |
| ie_i | input | 1 | Global enable for maskable sources |
| valid_o | output | 1 | A winner was selected |
| vec_o | output | 16 | Winner's vector word address |
| lvl_o | output | LVL_W | Winner's level (all ones for fixed-order winners) |
| rst_ack_o | output | 1 | Acknowledge to reset |
| nmi_ack_o | output | 1 | Acknowledge to NMI |
| wdt_ack_o | output | 1 | Acknowledge to watchdog |
| zdiv_ack_o | output | 1 | Acknowledge to zero divide |
| amatch_ack_o | output | 1 | Acknowledge to address match |
| irq_ack_o | output | N_MASK | Acknowledge to maskable source k |

## Verification
The bench builds the block with its defaults: eighteen maskable sources, 3-bit levels and a top maskable vector of 0xFFF2. This keeps the whole space small enough for near-exhaustive sweeps. It drives every single source at every level against every processor level with enable both on and off. It drives every ordered pair of sources at every pair of non-zero levels, which covers every tie and every level inversion. It also drives all 32 combinations of the fixed-order requests. Pseudo-random multi-source patterns and the all-equal-level case then exercise the tie rule across the full width of the scan.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W = 16;
  localparam int NFIX  = 5;
  // fixed-order slot index == rank
  localparam int FX_RST = 0;
  localparam int FX_NMI = 1;
  localparam int FX_WDT = 2;
  localparam int FX_ZDV = 3;
  localparam int FX_AMT = 4;
  localparam logic [VEC_W-1:0] V_RST = 16'hFFFE;
  localparam logic [VEC_W-1:0] V_ZDV = 16'hFFFC;
  localparam logic [VEC_W-1:0] V_BRK = 16'hFFFA;
  localparam logic [VEC_W-1:0] V_DBG = 16'hFFF8;
  localparam logic [VEC_W-1:0] V_WDT = 16'hFFF6;
  localparam logic [VEC_W-1:0] V_NMI = 16'hFFF4;
  localparam logic [VEC_W-1:0] V_AMT = 16'hFFCA;
endpackage

// File: rtl/irq_elig.sv
module irq_elig #(
  parameter int N_MASK = 18,
  parameter int LVL_W  = 3
) (
  input  logic [N_MASK-1:0]       req_i,
  input  logic [N_MASK*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]        ipl_i,
  input  logic                    ie_i,
  output logic [N_MASK-1:0]       elig_o
);
  for (genvar k = 0; k < N_MASK; k++) begin : g_src
    // level 0 can never exceed ipl, so it is implicitly disabled
    assign elig_o[k] = req_i[k] & ie_i & (lvl_i[k*LVL_W +: LVL_W] > ipl_i);
  end
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb #(
  parameter int N_MASK = 18,
  parameter int LVL_W  = 3,
  localparam int IDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
  input  logic [N_MASK-1:0]       elig_i,
  input  logic [N_MASK*LVL_W-1:0] lvl_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [LVL_W-1:0]        lvl_o
);
  // descending scan with >= : on equal level the lowest index survives
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int k = N_MASK - 1; k >= 0; k--) begin
      if (elig_i[k] && (!found_o || lvl_i[k*LVL_W +: LVL_W] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
        lvl_o   = lvl_i[k*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_fixed_sel.sv
module irq_fixed_sel
  import irq_pkg::*;
(
  input  logic [NFIX-1:0]  req_i,
  output logic [NFIX-1:0]  grant_o,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  assign grant_o = req_i & ~(req_i - NFIX'(1));
  assign any_o   = |req_i;

  always_comb begin
    vec_o = '0;
    unique case (1'b1)
      grant_o[FX_RST]: vec_o = V_RST;
      grant_o[FX_NMI]: vec_o = V_NMI;
      grant_o[FX_WDT]: vec_o = V_WDT;
      grant_o[FX_ZDV]: vec_o = V_ZDV;
      grant_o[FX_AMT]: vec_o = V_AMT;
      default:         vec_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver
  import irq_pkg::*;
#(
  parameter int              N_MASK   = 18,
  parameter int              LVL_W    = 3,
  parameter logic [15:0]     MASK_TOP = 16'hFFF2,
  localparam int             IDX_W    = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rst_req_i,
  input  logic                    nmi_req_i,
  input  logic                    wdt_req_i,
  input  logic                    zdiv_req_i,
  input  logic                    amatch_req_i,
  input  logic [N_MASK-1:0]       irq_req_i,
  input  logic [N_MASK*LVL_W-1:0] irq_lvl_i,
  input  logic [LVL_W-1:0]        ipl_i,
  input  logic                    ie_i,
  output logic                    valid_o,
  output logic [15:0]             vec_o,
  output logic [LVL_W-1:0]        lvl_o,
  output logic                    rst_ack_o,
  output logic                    nmi_ack_o,
  output logic                    wdt_ack_o,
  output logic                    zdiv_ack_o,
  output logic                    amatch_ack_o,
  output logic [N_MASK-1:0]       irq_ack_o
);
  logic [NFIX-1:0]   fix_req, fix_gnt;
  logic              fix_any;
  logic [VEC_W-1:0]  fix_vec;
  logic [N_MASK-1:0] elig;
  logic              m_found;
  logic [IDX_W-1:0]  m_idx;
  logic [LVL_W-1:0]  m_lvl;

  assign fix_req[FX_RST] = rst_req_i;
  assign fix_req[FX_NMI] = nmi_req_i;
  assign fix_req[FX_WDT] = wdt_req_i;
  assign fix_req[FX_ZDV] = zdiv_req_i;
  assign fix_req[FX_AMT] = amatch_req_i;

  irq_fixed_sel u_fix (
    .req_i  (fix_req),
    .grant_o(fix_gnt),
    .any_o  (fix_any),
    .vec_o  (fix_vec)
  );

  irq_elig #(.N_MASK(N_MASK), .LVL_W(LVL_W)) u_elig (
    .req_i (irq_req_i),
    .lvl_i (irq_lvl_i),
    .ipl_i (ipl_i),
    .ie_i  (ie_i),
    .elig_o(elig)
  );

  irq_lvl_arb #(.N_MASK(N_MASK), .LVL_W(LVL_W)) u_arb (
    .elig_i (elig),
    .lvl_i  (irq_lvl_i),
    .found_o(m_found),
    .idx_o  (m_idx),
    .lvl_o  (m_lvl)
  );

  logic              valid_d, valid_q;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic [LVL_W-1:0]  lvl_d, lvl_q;
  logic [NFIX-1:0]   fack_d, fack_q;
  logic [N_MASK-1:0] mack_d, mack_q;

  always_comb begin
    valid_d = 1'b0;
    vec_d   = '0;
    lvl_d   = '0;
    fack_d  = '0;
    mack_d  = '0;
    if (fix_any) begin
      valid_d = 1'b1;
      vec_d   = fix_vec;
      lvl_d   = '1;
      fack_d  = fix_gnt;
    end else if (m_found) begin
      valid_d = 1'b1;
      vec_d   = MASK_TOP - VEC_W'({m_idx, 1'b0});
      lvl_d   = m_lvl;
      mack_d  = N_MASK'(1) << m_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= '0;
      fack_q  <= '0;
      mack_q  <= '0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      lvl_q   <= lvl_d;
      fack_q  <= fack_d;
      mack_q  <= mack_d;
    end
  end

  assign valid_o      = valid_q;
  assign vec_o        = vec_q;
  assign lvl_o        = lvl_q;
  assign rst_ack_o    = fack_q[FX_RST];
  assign nmi_ack_o    = fack_q[FX_NMI];
  assign wdt_ack_o    = fack_q[FX_WDT];
  assign zdiv_ack_o   = fack_q[FX_ZDV];
  assign amatch_ack_o = fack_q[FX_AMT];
  assign irq_ack_o    = mack_q;

  // one edge out of reset before $past on inputs is meaningful
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R10
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_ack_o, amatch_ack_o, zdiv_ack_o, wdt_ack_o, nmi_ack_o, rst_ack_o}));

  // R10
  valid_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == |{irq_ack_o, amatch_ack_o, zdiv_ack_o, wdt_ack_o, nmi_ack_o, rst_ack_o});

  // R1
  rst_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rst_req_i) |-> rst_ack_o && vec_o == V_RST);

  // R2
  nmi_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(nmi_req_i && !rst_req_i) |-> nmi_ack_o && vec_o == V_NMI);

  // R6
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && (|irq_ack_o) |-> $past(ie_i) && lvl_o > $past(ipl_i));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(!(rst_req_i | nmi_req_i | wdt_req_i | zdiv_req_i | amatch_req_i)
                    && (!ie_i || irq_req_i == '0)) |-> !valid_o && vec_o == '0);

  // R11
  no_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o != V_BRK && vec_o != V_DBG);
endmodule

// File: tb/sim_irq_vec_resolver.sv
`timescale 1ns/1ps
module sim_irq_vec_resolver;
  localparam int N = 18;
  localparam int L = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_req_i, nmi_req_i, wdt_req_i, zdiv_req_i, amatch_req_i, ie_i;
  logic [N-1:0]   irq_req_i;
  logic [N*L-1:0] irq_lvl_i;
  logic [L-1:0]   ipl_i;
  logic           valid_o;
  logic [15:0]    vec_o;
  logic [L-1:0]   lvl_o;
  logic rst_ack_o, nmi_ack_o, wdt_ack_o, zdiv_ack_o, amatch_ack_o;
  logic [N-1:0]   irq_ack_o;

  always #5 clk_i = ~clk_i;

  irq_vec_resolver u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int reserved_seen = 0;

  function automatic logic [15:0] fix_vec(int b);
    case (b)
      0: return 16'hFFFE;
      1: return 16'hFFF4;
      2: return 16'hFFF6;
      3: return 16'hFFFC;
      default: return 16'hFFCA;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // inputs already set at a negedge; the result is registered at the next posedge
  task automatic step(string tag, bit ev, logic [15:0] evec, logic [L-1:0] elvl, logic [N+4:0] eack);
    @(negedge clk_i);
    if (vec_o == 16'hFFFA || vec_o == 16'hFFF8) reserved_seen++;
    chk({tag, " R8/R9"}, {43'd0, valid_o, vec_o, lvl_o}, {43'd0, ev, evec, elvl});
    chk({tag, " R10"},
        {41'd0, irq_ack_o, amatch_ack_o, zdiv_ack_o, wdt_ack_o, nmi_ack_o, rst_ack_o},
        {41'd0, eack});
  endtask

  task automatic clear_in();
    rst_req_i = 0; nmi_req_i = 0; wdt_req_i = 0; zdiv_req_i = 0; amatch_req_i = 0;
    irq_req_i = '0; irq_lvl_i = '0; ipl_i = '0; ie_i = 0;
  endtask

  function automatic logic [15:0] mvec(int k);
    return 16'(32'hFFF2 - 2 * k);
  endfunction

  initial begin
    clear_in();
    #1;
    chk("R12 reset valid/vec/lvl", {43'd0, valid_o, vec_o, lvl_o}, 64'd0);
    rst_req_i = 1; nmi_req_i = 1; irq_req_i = '1; irq_lvl_i = '1; ie_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R12 reset holds under requests", {42'd0, valid_o, irq_ack_o, rst_ack_o, nmi_ack_o, vec_o}, 64'd0);
    clear_in();
    rst_ni = 1;
    @(negedge clk_i);

    // R9 idle
    step("R9 idle", 0, 16'h0, 0, '0);

    // R5 R6 single maskable sweep
    for (int k = 0; k < N; k++)
      for (int lv = 0; lv < 8; lv++)
        for (int ip = 0; ip < 8; ip++)
          for (int e = 0; e < 2; e++) begin
            bit win;
            clear_in();
            irq_req_i[k] = 1; irq_lvl_i[k*L +: L] = L'(lv); ipl_i = L'(ip); ie_i = e[0];
            win = (e == 1) && (lv > ip);
            step($sformatf("R5/R6 src%0d lv%0d ipl%0d ie%0d", k, lv, ip, e),
                 win, win ? mvec(k) : 16'h0, win ? L'(lv) : L'(0),
                 win ? (N+5)'(1) << (5 + k) : '0);
          end

    // R7 every pair and level combination
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int li = 1; li < 8; li++)
          for (int lj = 1; lj < 8; lj++) begin
            int w;
            clear_in();
            ie_i = 1;
            irq_req_i[i] = 1; irq_req_i[j] = 1;
            irq_lvl_i[i*L +: L] = L'(li); irq_lvl_i[j*L +: L] = L'(lj);
            w = (lj > li) ? j : i;
            step($sformatf("R7 pair %0d/%0d lv %0d/%0d", i, j, li, lj),
                 1, mvec(w), L'((w == i) ? li : lj), (N+5)'(1) << (5 + w));
          end

    // R7 all equal level
    clear_in(); ie_i = 1; irq_req_i = '1;
    for (int k = 0; k < N; k++) irq_lvl_i[k*L +: L] = 3'd5;
    step("R7 all tie", 1, mvec(0), 3'd5, (N+5)'(1) << 5);

    // R1-style fixed order over all combinations, maskable at top level alongside
    for (int m = 0; m < 32; m++) begin
      int b;
      clear_in();
      {amatch_req_i, zdiv_req_i, wdt_req_i, nmi_req_i, rst_req_i} = 5'(m);
      irq_req_i = '1; irq_lvl_i = '1; ie_i = m[0]; ipl_i = 0;
      b = -1;
      for (int t = 4; t >= 0; t--) if (m[t]) b = t;
      if (b >= 0)
        step($sformatf("R1 R2 R3 R4 fixed m=%0d", m), 1, fix_vec(b), 3'd7, (N+5)'(1) << b);
      else if (ie_i)
        step("R4 fixed none", 1, mvec(0), 3'd7, (N+5)'(1) << 5);
      else
        step("R6 fixed none, disabled", 0, 16'h0, 0, '0);
    end

    // R4 fixed beats maskable even when maskable gated off
    clear_in(); amatch_req_i = 1; ie_i = 0; ipl_i = 3'd7;
    step("R4 amatch gate-free", 1, 16'hFFCA, 3'd7, (N+5)'(1) << 4);

    // R7 random multi-source
    for (int r = 0; r < 300; r++) begin
      int w; int bl;
      clear_in();
      ie_i = 1;
      irq_req_i = N'($urandom);
      irq_lvl_i = {$urandom, $urandom};
      ipl_i = L'($urandom_range(0, 3));
      w = -1; bl = -1;
      for (int k = 0; k < N; k++)
        if (irq_req_i[k] && int'(irq_lvl_i[k*L +: L]) > int'(ipl_i) && int'(irq_lvl_i[k*L +: L]) > bl) begin
          bl = irq_lvl_i[k*L +: L]; w = k;
        end
      if (w >= 0)
        step($sformatf("R7 rnd %0d", r), 1, mvec(w), L'(bl), (N+5)'(1) << (5 + w));
      else
        step($sformatf("R9 rnd %0d", r), 0, 16'h0, 0, '0);
    end

    // R9 back to idle
    clear_in();
    step("R9 return idle", 0, 16'h0, 0, '0);

    chk("R11 reserved vectors", 64'(reserved_seen), 64'd0);
    done = 1;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
  end

  initial begin
    wait (done);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    if (!done && checks > 0 && $time > 64'd1500000) begin
      done = 1;
    end
  end
endmodule